// File: doc/BRIEF.md
# ADC Output Word Formatter with Overrange Saturation

This block sits between the result selector of an interleaved conversion core and the external data pins. Each time the core presents a finished result together with a strobe, the formatter turns it into an output word. The word carries a straight-binary code of `RES_W` bits, a separate overrange flag and a data-valid pulse, and all three are registered on the rising clock edge.

The result from the core is one bit wider than the code. Its top bit means "above positive full scale". When that bit is set, the formatter raises the overrange flag and forces every code bit to one. The code therefore never wraps around to a small value.

An active-low enable controls the pin drivers. The formatter models this control as a drive-enable output and does not use real tri-state nets. The enable has no effect on the internal registers or on the data-valid pulse, so the pipeline keeps running while the bus is released.

Top module: `adc_word_formatter`

## Requirements
- R1: When a strobe is taken and bit `RES_W` of the result is 0, the code register loads result bits `RES_W-1:0` unchanged and the overrange flag is 0. With the default width, result 0 gives code 0x00, result 128 gives code 0x80 and result 255 gives code 0xFF.
- R2: When a strobe is taken and bit `RES_W` of the result is 1, the overrange flag is 1 after that edge, whatever the lower bits are.
- R3: While the overrange flag is 1, every code bit is 1.
- R4: The code and the flag change only on a rising edge where the strobe is high. On edges where the strobe is low, both keep their values whatever the result input carries.
- R5: The data-valid output is high for the single clock cycle after each edge that takes a strobe, and it is low after every edge without a strobe.
- R6: With the default `OE_REG = 0`, the drive-enable output equals the inverse of the active-low enable input in the same cycle. A high enable input does not stop the code, flag or data-valid outputs from updating.
- R7: While reset is low, the code, the overrange flag, the data-valid output and any registered drive enable are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| conv_result | input | RES_W+1 | Result from the core; the top bit means above full scale |
| conv_strobe | input | 1 | High for one cycle when conv_result holds a new result |
| out_en_n | input | 1 | Active-low output enable |
| code_o | output | RES_W | Registered straight-binary code |
| ovr_o | output | 1 | Registered overrange flag |
| dvalid_o | output | 1 | Pulse that marks a new word |
| drive_en_o | output | 1 | Pin drive enable for code_o and ovr_o (1 = drive) |

## Verification
The bench drives inputs on the falling edge. The code, the overrange flag and data-valid are registered, so each is due one rising edge after its stimulus, and the bench samples them at the next falling edge. The drive enable is combinational with the default parameters, so the bench samples it in the same half cycle in which the enable changes. The bench sweeps every value of the 9-bit result with the strobe high and the enable toggling. Between sweep steps it inserts cycles with no strobe and garbage on the result, which checks that the outputs hold and that data-valid drops.

// File: rtl/afmt_pkg.sv
package afmt_pkg;
   // Result of the clamp stage, ahead of the output registers
   typedef struct packed {
      logic       ovr;
      logic [7:0] code;
   } afmt_word8_t;

   function automatic logic is_above_fs(input logic top_bit);
      return top_bit;
   endfunction
endpackage

// File: rtl/afmt_clamp.sv
module afmt_clamp #(
   parameter int RES_W = 8
) (
   input  logic [RES_W:0]   result_i,
   output logic [RES_W-1:0] code_o,
   output logic             ovr_o
);
   import afmt_pkg::*;

   localparam logic [RES_W-1:0] FULL_SCALE = {RES_W{1'b1}};

   logic above_fs;

   always_comb begin
      above_fs = is_above_fs(result_i[RES_W]);
      ovr_o    = above_fs;
      if (above_fs) begin
         code_o = FULL_SCALE;
      end else begin
         code_o = result_i[RES_W-1:0];
      end
   end
endmodule

// File: rtl/afmt_outreg.sv
module afmt_outreg #(
   parameter int RES_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load_i,
   input  logic [RES_W-1:0] code_i,
   input  logic             ovr_i,
   output logic [RES_W-1:0] code_q,
   output logic             ovr_q,
   output logic             dvalid_q
);
   localparam logic [RES_W-1:0] ALL_ONES = {RES_W{1'b1}};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         code_q   <= '0;
         ovr_q    <= 1'b0;
         dvalid_q <= 1'b0;
      end else begin
         dvalid_q <= load_i;
         if (load_i) begin
            code_q <= code_i;
            ovr_q  <= ovr_i;
         end
      end
   end

   // R3: a raised flag always comes with a saturated code
   assert_ovr_saturates_R3: assert property (@(posedge clk) disable iff (!rst_n)
      ovr_q |-> (code_q == ALL_ONES));

   // R4: no strobe, no change
   assert_hold_without_strobe_R4: assert property (@(posedge clk) disable iff (!rst_n)
      !load_i |=> ($stable(code_q) && $stable(ovr_q)));

   // R5: data-valid follows the strobe by one edge
   assert_dvalid_after_strobe_R5: assert property (@(posedge clk) disable iff (!rst_n)
      load_i |=> dvalid_q);
   assert_dvalid_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
      !load_i |=> !dvalid_q);
endmodule

// File: rtl/afmt_drive.sv
module afmt_drive #(
   parameter bit OE_REG = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic out_en_n,
   output logic drive_en
);
   generate
      if (OE_REG) begin : g_reg_oe
         logic oe_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) oe_q <= 1'b0;
            else        oe_q <= !out_en_n;
         end
         assign drive_en = oe_q;
      end else begin : g_comb_oe
         assign drive_en = !out_en_n;
      end
   endgenerate
endmodule

// File: rtl/adc_word_formatter.sv
module adc_word_formatter #(
   parameter int RES_W  = 8,
   parameter bit OE_REG = 1'b0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [RES_W:0]   conv_result,
   input  logic             conv_strobe,
   input  logic             out_en_n,
   output logic [RES_W-1:0] code_o,
   output logic             ovr_o,
   output logic             dvalid_o,
   output logic             drive_en_o
);
   localparam int RESULT_W = RES_W + 1;

   generate
      if (RES_W < 2 || RES_W > 16) begin : g_bad_width
         $error("adc_word_formatter: RES_W must lie in 2..16");
      end
   endgenerate

   logic [RES_W-1:0] clamp_code;
   logic             clamp_ovr;
   logic [RESULT_W-1:0] result_w;

   assign result_w = conv_result;

   afmt_clamp #(.RES_W(RES_W)) u_clamp (
      .result_i (result_w),
      .code_o   (clamp_code),
      .ovr_o    (clamp_ovr)
   );

   afmt_outreg #(.RES_W(RES_W)) u_outreg (
      .clk      (clk),
      .rst_n    (rst_n),
      .load_i   (conv_strobe),
      .code_i   (clamp_code),
      .ovr_i    (clamp_ovr),
      .code_q   (code_o),
      .ovr_q    (ovr_o),
      .dvalid_q (dvalid_o)
   );

   afmt_drive #(.OE_REG(OE_REG)) u_drive (
      .clk      (clk),
      .rst_n    (rst_n),
      .out_en_n (out_en_n),
      .drive_en (drive_en_o)
   );

   // R2: an above-full-scale result taken on a strobe raises the flag
   assert_flag_on_over_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (conv_strobe && conv_result[RES_W]) |=> ovr_o);

   // R1: an in-range result taken on a strobe leaves the flag low
   assert_flag_clear_in_range_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (conv_strobe && !conv_result[RES_W]) |=> !ovr_o);
endmodule

// File: tb/adc_word_formatter_tb.sv
module adc_word_formatter_tb;
   localparam int RES_W = 8;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic [RES_W:0]   conv_result = '0;
   logic             conv_strobe = 1'b0;
   logic             out_en_n = 1'b1;
   logic [RES_W-1:0] code_o;
   logic             ovr_o;
   logic             dvalid_o;
   logic             drive_en_o;

   int checks = 0;
   int fails  = 0;
   logic [RES_W-1:0] exp_code = '0;
   logic             exp_ovr  = 1'b0;

   always #2.5 clk = ~clk;

   adc_word_formatter #(.RES_W(RES_W)) u_dut (
      .clk(clk), .rst_n(rst_n), .conv_result(conv_result),
      .conv_strobe(conv_strobe), .out_en_n(out_en_n),
      .code_o(code_o), .ovr_o(ovr_o), .dvalid_o(dvalid_o),
      .drive_en_o(drive_en_o)
   );

   task automatic chk(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   // drive at falling edge, pass one rising edge, check at next falling edge
   task automatic step(input logic [RES_W:0] res, input logic stb, input logic en_n);
      conv_result = res;
      conv_strobe = stb;
      out_en_n    = en_n;
      #0.5;
      chk("R6 drive enable", int'(drive_en_o), int'(!en_n));
      @(posedge clk);
      if (stb) begin
         if (res[RES_W]) begin
            exp_code = '1;
            exp_ovr  = 1'b1;
         end else begin
            exp_code = res[RES_W-1:0];
            exp_ovr  = 1'b0;
         end
      end
      @(negedge clk);
      if (stb && !res[RES_W]) chk("R1 code", int'(code_o), int'(exp_code));
      else if (stb)           chk("R3 saturated code", int'(code_o), int'(exp_code));
      else                    chk("R4 held code", int'(code_o), int'(exp_code));
      if (stb) chk("R2 overrange flag", int'(ovr_o), int'(exp_ovr));
      else     chk("R4 held flag", int'(ovr_o), int'(exp_ovr));
      chk("R5 data valid", int'(dvalid_o), int'(stb));
      chk("R6 drive enable after edge", int'(drive_en_o), int'(!en_n));
   endtask

   task automatic reset_check();
      @(negedge clk);
      rst_n = 1'b0;
      #0.5;
      chk("R7 reset code", int'(code_o), 0);
      chk("R7 reset flag", int'(ovr_o), 0);
      chk("R7 reset valid", int'(dvalid_o), 0);
      exp_code = '0;
      exp_ovr  = 1'b0;
      @(negedge clk);
      rst_n = 1'b1;
   endtask

   initial begin
      #(5.0 * 200000);
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      reset_check();

      // R1 named points
      step(9'd0,   1'b1, 1'b0);
      step(9'd128, 1'b1, 1'b0);
      step(9'd255, 1'b1, 1'b0);
      // R2, R3 just above full scale
      step(9'd256, 1'b1, 1'b0);

      // full sweep with enable toggling; R6 registers keep updating while released
      for (int v = 0; v < 512; v++) begin
         step(v[RES_W:0], 1'b1, v[0]);
         // R4/R5: idle cycle with garbage on the result
         if (v % 7 == 3) step(~v[RES_W:0], 1'b0, v[1]);
      end

      // R4 hold after an overrange word, then after an in-range word
      step(9'd300, 1'b1, 1'b1);
      step(9'd5,   1'b0, 1'b0);
      step(9'd17,  1'b0, 1'b1);
      step(9'd42,  1'b1, 1'b0);
      step(9'd511, 1'b0, 1'b0);
      step(9'd256, 1'b0, 1'b1);

      // R7 reset mid-stream after overrange
      step(9'd400, 1'b1, 1'b0);
      reset_check();
      step(9'd77, 1'b0, 1'b0);
      step(9'd77, 1'b1, 1'b0);

      $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end
endmodule